// File: doc/BRIEF.md
# Compare-and-Jump Resolution Unit

This block settles control transfers in a small processor pipeline by comparing two operands directly instead of consulting stored condition flags. A conditional jump arrives either in register form, where the first source register is tested against a second source register, or in immediate form, where it is tested against a 16-bit constant carried in the instruction. A 4-bit condition field picks the test. A passing test loads the instruction pointer from a dedicated jump-address register. A failing test advances the pointer by one word.

The same unit drives the stack side of subroutine calls and returns. A call pushes the current instruction pointer and then jumps to the jump-address register. A return pops the pointer from the stack. The register file, instruction fetch and the stack memory are outside the block. The unit receives operand values, the current pointers and the jump-address register. It returns an update of the pointers, stack read and write strobes, and an exception request for condition codes that are not defined.

Top module: `cjmp_unit`

## Requirements
- R1: Field decode: the condition code is instr[23:20] and the first source index is instr[19:16] (`src_a_idx`). The register form takes its second source index from instr[15:12] (`src_b_idx`). The immediate form takes its 16-bit immediate from instr[15:0]. Operation kind encoding: 0 is register-form jump, 1 is immediate-form jump, 2 is call and 3 is return.
- R2: Condition 0x0 always jumps. Condition 0x1 jumps when the operands differ. Condition 0x2 jumps when they are equal.
- R3: Condition 0x3 jumps on unsigned greater-than. Condition 0x4 jumps on unsigned greater-or-equal.
- R4: Condition 0xC jumps on signed greater-than. Condition 0xD jumps on signed greater-or-equal.
- R5: In the immediate form, the immediate is sign-extended for conditions 0xC and 0xD and zero-extended for every other condition. In the immediate form, `rs2_val` is ignored.
- R6: In the cycle after an accepted jump with a passing test, `ip_load` and `taken` are high and `ip_next` equals `jmp_reg`. Both strobes last one cycle.
- R7: In the cycle after an accepted jump with a failing test, `ip_load` is high, `taken` is low and `ip_next` is `ip_cur + 1`.
- R8: A jump with condition 0x5 to 0xB, 0xE or 0xF raises `exc_valid` with `exc_vec` = 3 in the following cycle. In that cycle there is no pointer load and no stack access.
- R9: In the cycle after an accepted call, the unit drives `push_en` with `push_addr` = `sp_cur + 1` and `push_data` = `ip_cur`. In the same cycle it drives `sp_load` with `sp_next` = `sp_cur + 1`, and `ip_load` with `ip_next` = `jmp_reg`.
- R10: In the cycle after an accepted return, the unit drives `pop_en` with `pop_addr` = `sp_cur`. It holds `in_ready` low for that cycle and the next. It captures `stack_rdata` at the end of that next cycle. One cycle later it drives `ip_load` with `ip_next` equal to the captured word, and `sp_load` with `sp_next` = `sp_cur - 1`.
- R11: During and straight after reset, all strobes are low and `in_ready` is high.
- R12: When `in_valid` is low, no strobe rises in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can accept an operation |
| in_kind | input | 2 | 0 register jump, 1 immediate jump, 2 call, 3 return |
| instr | input | 32 | Instruction word |
| src_a_idx | output | 4 | First source register index |
| src_b_idx | output | 4 | Second source register index |
| rs1_val | input | 32 | First operand value |
| rs2_val | input | 32 | Second operand value (register form) |
| ip_cur | input | 32 | Current instruction pointer |
| jmp_reg | input | 32 | Jump-address register |
| sp_cur | input | 32 | Current stack pointer |
| stack_rdata | input | 32 | Stack read data, one cycle after `pop_en` |
| ip_load | output | 1 | Load instruction pointer |
| ip_next | output | 32 | New instruction pointer |
| taken | output | 1 | Conditional jump passed |
| sp_load | output | 1 | Load stack pointer |
| sp_next | output | 32 | New stack pointer |
| push_en | output | 1 | Stack write strobe |
| push_addr | output | 32 | Stack write address |
| push_data | output | 32 | Stack write data |
| pop_en | output | 1 | Stack read strobe |
| pop_addr | output | 32 | Stack read address |
| exc_valid | output | 1 | Exception request |
| exc_vec | output | 5 | Exception vector |

## Verification
The bench targets the sign boundary. It uses operands of 0x80000000 against 0x7FFFFFFF, and -1 against +1. A comparator that mixes up signed and unsigned order flips exactly these outcomes. It also probes immediates with bit 15 set. There, using the wrong extension makes an equality test pass against 0xFFFFFFFF, or makes the unsigned test treat 0x8000 as negative. Undefined condition codes at both ends of the gaps are checked to raise vector 3 and to leave the pointer alone. The return path is checked on the exact cycle the popped word appears, so that an off-by-one in the read latency, or a stack pointer decremented before the read, shows as a wrong `ip_next` or `sp_next`.

// File: rtl/cjmp_pkg.sv
package cjmp_pkg;
   typedef enum logic [1:0] {
      OP_JREG = 2'd0,
      OP_JIMM = 2'd1,
      OP_CALL = 2'd2,
      OP_RET  = 2'd3
   } op_kind_e;

   localparam logic [3:0] CC_ALWAYS = 4'h0;
   localparam logic [3:0] CC_NE     = 4'h1;
   localparam logic [3:0] CC_EQ     = 4'h2;
   localparam logic [3:0] CC_UGT    = 4'h3;
   localparam logic [3:0] CC_UGE    = 4'h4;
   localparam logic [3:0] CC_SGT    = 4'hC;
   localparam logic [3:0] CC_SGE    = 4'hD;

   typedef enum logic [1:0] {
      ST_RUN      = 2'd0,
      ST_POP_REQ  = 2'd1,
      ST_POP_WAIT = 2'd2
   } ctl_state_e;

   function automatic logic is_signed_cc(input logic [3:0] cc);
      return (cc == CC_SGT) || (cc == CC_SGE);
   endfunction
endpackage

// File: rtl/cjmp_operand.sv
module cjmp_operand #(
   parameter int DW    = 32,
   parameter int IMM_W = 16
) (
   input  logic             use_imm,
   input  logic             sign_ext,
   input  logic [DW-1:0]    reg_val,
   input  logic [IMM_W-1:0] imm,
   output logic [DW-1:0]    opnd
);
   localparam int PAD_W = DW - IMM_W;

   logic [DW-1:0] imm_wide;

   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_wide = {{PAD_W{sign_ext & imm[IMM_W-1]}}, imm};
      end else begin : g_nopad
         assign imm_wide = imm[DW-1:0];
      end
   endgenerate

   assign opnd = use_imm ? imm_wide : reg_val;
endmodule

// File: rtl/cjmp_cond.sv
module cjmp_cond #(
   parameter int DW        = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [3:0]    cc,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic          pass,
   output logic          bad_cc
);
   import cjmp_pkg::*;

   logic eq, ugt, sgt, sgn_ok;

   assign eq  = (a == b);
   assign ugt = (a > b);

   generate
      if (SIGNED_EN) begin : g_sgn
         assign sgt    = ($signed(a) > $signed(b));
         assign sgn_ok = 1'b1;
      end else begin : g_nosgn
         assign sgt    = 1'b0;
         assign sgn_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      pass   = 1'b0;
      bad_cc = 1'b0;
      case (cc)
         CC_ALWAYS: pass = 1'b1;
         CC_NE:     pass = !eq;
         CC_EQ:     pass = eq;
         CC_UGT:    pass = ugt;
         CC_UGE:    pass = ugt | eq;
         CC_SGT: begin
            pass   = sgn_ok & sgt;
            bad_cc = !sgn_ok;
         end
         CC_SGE: begin
            pass   = sgn_ok & (sgt | eq);
            bad_cc = !sgn_ok;
         end
         default:   bad_cc = 1'b1;
      endcase
   end
endmodule

// File: rtl/cjmp_stack.sv
module cjmp_stack #(
   parameter int DW   = 32,
   parameter int STEP = 1
) (
   input  logic [DW-1:0] sp,
   output logic [DW-1:0] sp_up,
   output logic [DW-1:0] sp_down
);
   localparam logic [DW-1:0] STEP_V = DW'(STEP);

   assign sp_up   = sp + STEP_V;
   assign sp_down = sp - STEP_V;
endmodule

// File: rtl/cjmp_unit.sv
module cjmp_unit #(
   parameter int DW          = 32,
   parameter int IW          = 32,
   parameter int IMM_W       = 16,
   parameter int IDX_W       = 4,
   parameter int STEP        = 1,
   parameter int VEC_W       = 5,
   parameter int BAD_OP_VEC  = 3,
   parameter bit SIGNED_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [1:0]       in_kind,
   input  logic [IW-1:0]    instr,
   output logic [IDX_W-1:0] src_a_idx,
   output logic [IDX_W-1:0] src_b_idx,
   input  logic [DW-1:0]    rs1_val,
   input  logic [DW-1:0]    rs2_val,
   input  logic [DW-1:0]    ip_cur,
   input  logic [DW-1:0]    jmp_reg,
   input  logic [DW-1:0]    sp_cur,
   input  logic [DW-1:0]    stack_rdata,
   output logic             ip_load,
   output logic [DW-1:0]    ip_next,
   output logic             taken,
   output logic             sp_load,
   output logic [DW-1:0]    sp_next,
   output logic             push_en,
   output logic [DW-1:0]    push_addr,
   output logic [DW-1:0]    push_data,
   output logic             pop_en,
   output logic [DW-1:0]    pop_addr,
   output logic             exc_valid,
   output logic [VEC_W-1:0] exc_vec
);
   import cjmp_pkg::*;

   localparam int B_LSB   = IMM_W - IDX_W;
   localparam int A_LSB   = IMM_W;
   localparam int CC_LSB  = A_LSB + IDX_W;
   localparam int CC_MSB  = CC_LSB + 3;
   localparam logic [DW-1:0]    STEP_V = DW'(STEP);
   localparam logic [VEC_W-1:0] VEC_V  = VEC_W'(BAD_OP_VEC);

   generate
      if (IMM_W > DW) begin : g_bad_imm
         $error("immediate wider than data path");
      end
      if (CC_MSB >= IW) begin : g_bad_fields
         $error("instruction fields exceed instruction width");
      end
      if (BAD_OP_VEC >= (1 << VEC_W)) begin : g_bad_vec
         $error("exception vector does not fit");
      end
   endgenerate

   // field decode
   logic [3:0]       cc;
   logic [IMM_W-1:0] imm;
   logic             unused_hi;

   assign cc        = instr[CC_MSB:CC_LSB];
   assign src_a_idx = instr[A_LSB +: IDX_W];
   assign src_b_idx = instr[B_LSB +: IDX_W];
   assign imm       = instr[IMM_W-1:0];
   assign unused_hi = ^instr[IW-1:CC_MSB+1];

   op_kind_e kind;
   assign kind = op_kind_e'(in_kind);

   logic [DW-1:0] opnd_b;
   logic          cc_pass, cc_bad;
   logic [DW-1:0] sp_up, sp_down;

   cjmp_operand #(.DW(DW), .IMM_W(IMM_W)) u_opnd (
      .use_imm (kind == OP_JIMM),
      .sign_ext(is_signed_cc(cc)),
      .reg_val (rs2_val),
      .imm     (imm),
      .opnd    (opnd_b)
   );

   cjmp_cond #(.DW(DW), .SIGNED_EN(SIGNED_EN)) u_cond (
      .cc    (cc),
      .a     (rs1_val),
      .b     (opnd_b),
      .pass  (cc_pass),
      .bad_cc(cc_bad)
   );

   cjmp_stack #(.DW(DW), .STEP(STEP)) u_stack (
      .sp     (sp_cur),
      .sp_up  (sp_up),
      .sp_down(sp_down)
   );

   ctl_state_e    state;
   logic [DW-1:0] ret_sp_dn;
   logic          accept;

   assign in_ready = (state == ST_RUN);
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_RUN;
         ret_sp_dn <= '0;
         ip_load   <= 1'b0;
         ip_next   <= '0;
         taken     <= 1'b0;
         sp_load   <= 1'b0;
         sp_next   <= '0;
         push_en   <= 1'b0;
         push_addr <= '0;
         push_data <= '0;
         pop_en    <= 1'b0;
         pop_addr  <= '0;
         exc_valid <= 1'b0;
         exc_vec   <= '0;
      end else begin
         ip_load   <= 1'b0;
         taken     <= 1'b0;
         sp_load   <= 1'b0;
         push_en   <= 1'b0;
         pop_en    <= 1'b0;
         exc_valid <= 1'b0;
         case (state)
            ST_RUN: begin
               if (accept) begin
                  case (kind)
                     OP_JREG, OP_JIMM: begin
                        if (cc_bad) begin
                           exc_valid <= 1'b1;
                           exc_vec   <= VEC_V;
                        end else begin
                           ip_load <= 1'b1;
                           taken   <= cc_pass;
                           ip_next <= cc_pass ? jmp_reg : ip_cur + STEP_V;
                        end
                     end
                     OP_CALL: begin
                        push_en   <= 1'b1;
                        push_addr <= sp_up;
                        push_data <= ip_cur;
                        sp_load   <= 1'b1;
                        sp_next   <= sp_up;
                        ip_load   <= 1'b1;
                        ip_next   <= jmp_reg;
                     end
                     default: begin
                        pop_en    <= 1'b1;
                        pop_addr  <= sp_cur;
                        ret_sp_dn <= sp_down;
                        state     <= ST_POP_REQ;
                     end
                  endcase
               end
            end
            ST_POP_REQ: state <= ST_POP_WAIT;
            default: begin
               ip_load <= 1'b1;
               ip_next <= stack_rdata;
               sp_load <= 1'b1;
               sp_next <= ret_sp_dn;
               state   <= ST_RUN;
            end
         endcase
      end
   end

   // R6
   taken_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> ip_load && ip_next == $past(jmp_reg));

   // R8
   bad_cc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> !ip_load && !push_en && !pop_en && !sp_load && exc_vec == VEC_V);

   // R9
   push_sp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |-> sp_load && sp_next == push_addr && push_addr == $past(sp_cur) + STEP_V);

   // R10
   pop_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> !in_ready ##1 !in_ready && !ip_load);

   // R10
   pop_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pop_en, 2) |-> ip_load && sp_load && ip_next == $past(stack_rdata)
                           && sp_next == $past(pop_addr, 2) - STEP_V);

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> !exc_valid && !push_en && !pop_en);
endmodule

// File: tb/cjmp_unit_test.sv
`timescale 1ns/1ps
module cjmp_unit_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [1:0]  in_kind;
   logic [31:0] instr;
   logic [3:0]  src_a_idx, src_b_idx;
   logic [31:0] rs1_val, rs2_val, ip_cur, jmp_reg, sp_cur, stack_rdata;
   logic        ip_load, taken, sp_load, push_en, pop_en, exc_valid;
   logic [31:0] ip_next, sp_next, push_addr, push_data, pop_addr;
   logic [4:0]  exc_vec;

   always #2 clk = ~clk;

   cjmp_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(in_kind), .instr(instr), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
      .rs1_val(rs1_val), .rs2_val(rs2_val), .ip_cur(ip_cur), .jmp_reg(jmp_reg),
      .sp_cur(sp_cur), .stack_rdata(stack_rdata), .ip_load(ip_load), .ip_next(ip_next),
      .taken(taken), .sp_load(sp_load), .sp_next(sp_next), .push_en(push_en),
      .push_addr(push_addr), .push_data(push_data), .pop_en(pop_en), .pop_addr(pop_addr),
      .exc_valid(exc_valid), .exc_vec(exc_vec)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [1:0]  kind;
      logic [3:0]  cc;
      logic [31:0] a;
      logic [31:0] b;
      logic        tk;
      logic        ex;
   } vec_t;

   // kind 0 register form, kind 1 immediate form (b[15:0] is the immediate)
   localparam int NV = 22;
   localparam vec_t TBL [NV] = '{
      '{2'd0, 4'h0, 32'd5,        32'd9,        1'b1, 1'b0},  // R2
      '{2'd0, 4'h1, 32'd5,        32'd5,        1'b0, 1'b0},  // R2
      '{2'd0, 4'h1, 32'd5,        32'd6,        1'b1, 1'b0},  // R2
      '{2'd0, 4'h2, 32'd7,        32'd7,        1'b1, 1'b0},  // R2
      '{2'd0, 4'h2, 32'd7,        32'd8,        1'b0, 1'b0},  // R2
      '{2'd0, 4'h3, 32'hFFFFFFFF, 32'd1,        1'b1, 1'b0},  // R3
      '{2'd0, 4'h3, 32'd1,        32'd1,        1'b0, 1'b0},  // R3
      '{2'd0, 4'h4, 32'd1,        32'd1,        1'b1, 1'b0},  // R3
      '{2'd0, 4'h4, 32'd0,        32'd1,        1'b0, 1'b0},  // R3
      '{2'd0, 4'hC, 32'hFFFFFFFF, 32'd1,        1'b0, 1'b0},  // R4
      '{2'd0, 4'hC, 32'd1,        32'hFFFFFFFF, 1'b1, 1'b0},  // R4
      '{2'd0, 4'hD, 32'h80000000, 32'h80000000, 1'b1, 1'b0},  // R4
      '{2'd0, 4'hD, 32'h80000000, 32'h7FFFFFFF, 1'b0, 1'b0},  // R4
      '{2'd0, 4'h5, 32'd1,        32'd1,        1'b0, 1'b1},  // R8
      '{2'd0, 4'hF, 32'd1,        32'd1,        1'b0, 1'b1},  // R8
      '{2'd1, 4'h2, 32'h0000FFFF, 32'h0000FFFF, 1'b1, 1'b0},  // R5
      '{2'd1, 4'h2, 32'hFFFFFFFF, 32'h0000FFFF, 1'b0, 1'b0},  // R5
      '{2'd1, 4'hD, 32'hFFFFFFFF, 32'h0000FFFF, 1'b1, 1'b0},  // R5
      '{2'd1, 4'hC, 32'd0,        32'h00008000, 1'b1, 1'b0},  // R5
      '{2'd1, 4'h3, 32'd0,        32'h00008000, 1'b0, 1'b0},  // R5
      '{2'd1, 4'h4, 32'h00008000, 32'h00008000, 1'b1, 1'b0},  // R5
      '{2'd1, 4'hB, 32'd1,        32'd1,        1'b0, 1'b1}   // R8
   };

   task automatic issue();
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_kind = 2'd0; instr = '0;
      rs1_val = '0; rs2_val = '0; ip_cur = 32'h100; jmp_reg = 32'hABC0;
      sp_cur = 32'h40; stack_rdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset state
      chk("R11 in_ready", {31'd0, in_ready}, 32'd1);
      chk("R11 strobes", {26'd0, ip_load, taken, sp_load, push_en, pop_en, exc_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         in_kind = TBL[i].kind;
         rs1_val = TBL[i].a;
         if (TBL[i].kind == 2'd1) begin
            instr   = {8'h00, TBL[i].cc, 4'h6, TBL[i].b[15:0]};
            rs2_val = 32'hDEADBEEF;
         end else begin
            instr   = {8'h00, TBL[i].cc, 4'h6, 16'h3ABC};
            rs2_val = TBL[i].b;
         end
         #1;
         // R1 field decode
         chk("R1 src_a_idx", {28'd0, src_a_idx}, 32'd6);
         chk("R1 src_b_idx", {28'd0, src_b_idx},
             (TBL[i].kind == 2'd1) ? {28'd0, TBL[i].b[15:12]} : 32'd3);
         issue();
         if (TBL[i].ex) begin
            chk("R8 exc_valid", {31'd0, exc_valid}, 32'd1);
            chk("R8 exc_vec", {27'd0, exc_vec}, 32'd3);
            chk("R8 no load", {29'd0, ip_load, push_en, pop_en}, 32'd0);
         end else begin
            chk("R6 R7 ip_load", {31'd0, ip_load}, 32'd1);
            chk("R2 R3 R4 R5 taken", {31'd0, taken}, {31'd0, TBL[i].tk});
            chk("R6 R7 ip_next", ip_next, TBL[i].tk ? 32'hABC0 : 32'h101);
            chk("R8 no exc", {31'd0, exc_valid}, 32'd0);
         end
      end

      // R6 one-cycle pulse
      in_kind = 2'd0; instr = {8'h00, 4'h0, 4'h1, 16'h2000};
      issue();
      chk("R6 taken", {31'd0, taken}, 32'd1);
      @(negedge clk);
      chk("R6 pulse ends", {30'd0, ip_load, taken}, 32'd0);

      // R12 no operation without in_valid
      jmp_reg = 32'h5555;
      @(posedge clk);
      @(negedge clk);
      chk("R12 idle", {26'd0, ip_load, taken, sp_load, push_en, pop_en, exc_valid}, 32'd0);
      jmp_reg = 32'hABC0;

      // R9 call
      in_kind = 2'd2; ip_cur = 32'h100; sp_cur = 32'h40; instr = '0;
      issue();
      chk("R9 push_en", {31'd0, push_en}, 32'd1);
      chk("R9 push_addr", push_addr, 32'h41);
      chk("R9 push_data", push_data, 32'h100);
      chk("R9 sp_next", sp_load ? sp_next : 32'hX, 32'h41);
      chk("R9 ip_next", ip_load ? ip_next : 32'hX, 32'hABC0);

      // R10 return
      in_kind = 2'd3; sp_cur = 32'h41; stack_rdata = 32'h0000_0777;
      issue();
      chk("R10 pop_en", {31'd0, pop_en}, 32'd1);
      chk("R10 pop_addr", pop_addr, 32'h41);
      chk("R10 ready low", {31'd0, in_ready}, 32'd0);
      chk("R10 no early load", {31'd0, ip_load}, 32'd0);
      sp_cur = 32'h99;
      @(negedge clk);
      chk("R10 wait ready", {31'd0, in_ready}, 32'd0);
      chk("R10 wait quiet", {30'd0, ip_load, pop_en}, 32'd0);
      @(negedge clk);
      chk("R10 ip_load", {31'd0, ip_load}, 32'd1);
      chk("R10 ip_next", ip_next, 32'h777);
      chk("R10 sp_next", sp_load ? sp_next : 32'hX, 32'h40);
      chk("R10 ready back", {31'd0, in_ready}, 32'd1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule